// File: doc/BRIEF.md
# Receiver Full Reset Sequencer

This block stands between a user's request to fully reset a serial transceiver's receive path and the channel itself. A request is not passed through directly. The block asserts a registered reset toward the channel. While that reset is held, it reads one configuration word over the channel's dynamic reconfiguration port (DRP). It then writes the word back with bit 11 forced to zero. All other bits of the word keep their values.

The reset is released only once two conditions hold: the clearing write has been acknowledged and the user request has dropped. After release, the block waits for the channel's PMA reset-done status to fall. It then writes the saved word back unchanged, which restores bit 11. This restore write must be acknowledged while reset-done is still low. The low window is at least 0.66 us, so the worst-case DRP latency must fit inside it.

A parameter selects a simulation speed-up mode. In that mode the sequence is skipped, and the reset output is simply a registered copy of the request.

Top module: `rx_full_reset_seq`

## Requirements
- R1: In sequenced mode, a request seen high while the block is idle makes the reset output and busy go high at the next clock edge. Both outputs are low after reset.
- R2: The first DRP transaction is a read of address 9'h011. The second is a write to the same address whose data equals the read word with bit 11 cleared.
- R3: The reset output stays high until the clearing write has been acknowledged and the request is low. It stays high for as long as the request is held, even after the write has completed.
- R4: After the reset is released, no DRP transaction starts until reset-done falls, meaning it is 1 in one cycle and 0 in the next.
- R5: The falling edge launches a write to 9'h011 whose data is the full word captured by the read, so bit 11 is restored.
- R6: Busy falls at the clock edge where the acknowledge of the restore write is seen. The whole restore takes at most DRP latency plus 3 cycles from the falling edge.
- R7: With the speed-up parameter set, the reset output equals the request delayed by one clock. In this mode busy and the DRP enable stay low.
- R8: Every DRP enable is a one-cycle pulse. No new enable is issued while a transaction is awaiting its ready.
- R9: A request raised while busy is high has no effect: the reset output stays low and no extra DRP transaction is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| user_req | input | 1 | User receive full-reset request, level |
| pma_done | input | 1 | PMA reset-done status from the channel |
| drp_rdy | input | 1 | DRP transaction acknowledge |
| drp_do | input | 16 | DRP read data |
| gt_rx_rst | output | 1 | Registered receive reset to the channel |
| drp_en | output | 1 | DRP enable, one-cycle pulse |
| drp_we | output | 1 | DRP write enable, qualified by drp_en |
| drp_addr | output | 9 | DRP address |
| drp_di | output | 16 | DRP write data |
| busy | output | 1 | High from request acceptance to restore completion |

## Verification
A corrupted stored word shows up in the data of the clearing write, one cycle after the read acknowledge. It also shows up in the restore write, one cycle after reset-done falls. The bench compares both against its own model of the configuration register. A state register stuck or skipping a step appears in one of two ways. Either the reset output falls while the request is still high or before the clearing write lands, or the DRP transaction count differs from three. The reset-output fall is sampled each cycle. The transaction count is compared at release, before the falling edge, and after the restore.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ      = 3'd1,
        ST_CLEAR     = 3'd2,
        ST_HOLD      = 3'd3,
        ST_WAIT_FALL = 3'd4,
        ST_RESTORE   = 3'd5
    } seq_state_e;

endpackage

// File: rtl/rxfr_fall_det.sv
module rxfr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
    } fd_regs_t;

    fd_regs_t fd_d, fd_q;

    always_comb begin
        fd_d      = fd_q;
        fd_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fd_q <= '0;
        else        fd_q <= fd_d;
    end

    assign fall_o = fd_q.prev & ~sig_i;
endmodule

// File: rtl/rxfr_drp_xact.sv
module rxfr_drp_xact #(
    parameter int               AW   = 9,
    parameter int               DW   = 16,
    parameter logic [AW-1:0]    ADDR = 9'h011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          drp_rdy_i,
    input  logic [DW-1:0] drp_do_i,
    output logic          idle_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic          drp_en_o,
    output logic          drp_we_o,
    output logic [AW-1:0] drp_addr_o,
    output logic [DW-1:0] drp_di_o
);
    typedef struct packed {
        logic          en;
        logic          we;
        logic [DW-1:0] di;
        logic          pending;
    } xa_regs_t;

    xa_regs_t xa_d, xa_q;

    assign done_o = xa_q.pending & drp_rdy_i;
    assign idle_o = ~xa_q.pending | drp_rdy_i;

    always_comb begin
        xa_d    = xa_q;
        xa_d.en = 1'b0;
        if (done_o) xa_d.pending = 1'b0;
        if (start_i && idle_o) begin
            xa_d.en      = 1'b1;
            xa_d.we      = we_i;
            xa_d.di      = we_i ? wdata_i : '0;
            xa_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xa_q <= '0;
        else        xa_q <= xa_d;
    end

    assign drp_en_o   = xa_q.en;
    assign drp_we_o   = xa_q.en & xa_q.we;
    assign drp_addr_o = ADDR;
    assign drp_di_o   = xa_q.di;
    assign rdata_o    = drp_do_i;

    AST_EN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en_o |=> !drp_en_o) else $error("enable longer than one cycle"); // R8
    AST_NO_SECOND_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (xa_q.pending && !drp_rdy_i) |=> !drp_en_o) else $error("overlapping transaction"); // R8
endmodule

// File: rtl/rx_full_reset_seq.sv
module rx_full_reset_seq #(
    parameter int            AW          = 9,
    parameter int            DW          = 16,
    parameter logic [AW-1:0] CFG_ADDR    = 9'h011,
    parameter int            CFG_BIT     = 11,
    parameter bit            SIM_SPEEDUP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          user_req,
    input  logic          pma_done,
    input  logic          drp_rdy,
    input  logic [DW-1:0] drp_do,
    output logic          gt_rx_rst,
    output logic          drp_en,
    output logic          drp_we,
    output logic [AW-1:0] drp_addr,
    output logic [DW-1:0] drp_di,
    output logic          busy
);
    import rxfr_pkg::*;

    localparam logic [DW-1:0] CLR_MASK = ~(DW'(1) << CFG_BIT);

    typedef struct packed {
        seq_state_e    state;
        logic          rst;
        logic [DW-1:0] word;
    } seq_regs_t;

    seq_regs_t     seq_d, seq_q;
    logic          x_start, x_we, x_idle, x_done, pma_fall;
    logic [DW-1:0] x_wdata, x_rdata;

    rxfr_drp_xact #(.AW(AW), .DW(DW), .ADDR(CFG_ADDR)) i_xact (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (x_start),
        .we_i       (x_we),
        .wdata_i    (x_wdata),
        .drp_rdy_i  (drp_rdy),
        .drp_do_i   (drp_do),
        .idle_o     (x_idle),
        .done_o     (x_done),
        .rdata_o    (x_rdata),
        .drp_en_o   (drp_en),
        .drp_we_o   (drp_we),
        .drp_addr_o (drp_addr),
        .drp_di_o   (drp_di)
    );

    rxfr_fall_det i_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (pma_done),
        .fall_o (pma_fall)
    );

    always_comb begin
        seq_d   = seq_q;
        x_start = 1'b0;
        x_we    = 1'b0;
        x_wdata = seq_q.word;
        if (SIM_SPEEDUP) begin
            seq_d.state = ST_IDLE;
            seq_d.rst   = user_req;
        end else begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    if (user_req && x_idle) begin
                        seq_d.rst   = 1'b1;
                        seq_d.state = ST_READ;
                        x_start     = 1'b1;
                    end
                end
                ST_READ: begin
                    if (x_done) begin
                        seq_d.word  = x_rdata;
                        x_start     = 1'b1;
                        x_we        = 1'b1;
                        x_wdata     = x_rdata & CLR_MASK;
                        seq_d.state = ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    if (x_done) begin
                        if (!user_req) begin
                            seq_d.rst   = 1'b0;
                            seq_d.state = ST_WAIT_FALL;
                        end else begin
                            seq_d.state = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!user_req) begin
                        seq_d.rst   = 1'b0;
                        seq_d.state = ST_WAIT_FALL;
                    end
                end
                ST_WAIT_FALL: begin
                    if (pma_fall) begin
                        x_start     = 1'b1;
                        x_we        = 1'b1;
                        x_wdata     = seq_q.word;
                        seq_d.state = ST_RESTORE;
                    end
                end
                ST_RESTORE: begin
                    if (x_done) seq_d.state = ST_IDLE;
                end
                default: seq_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.rst   <= 1'b0;
            seq_q.word  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign gt_rx_rst = seq_q.rst;
    assign busy      = (seq_q.state != ST_IDLE);

    generate
        if (SIM_SPEEDUP) begin : g_fast_chk
            AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (gt_rx_rst == $past(user_req))) else $error("bypass mismatch"); // R7
            AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !busy && !drp_en) else $error("activity in bypass"); // R7
        end else begin : g_seq_chk
            AST_REQ_TO_RST: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy && user_req) |=> (gt_rx_rst && busy)) else $error("request not taken"); // R1
            AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                (gt_rx_rst && user_req) |=> gt_rx_rst) else $error("reset dropped early"); // R3
            AST_CLEAR_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (drp_en && drp_we && gt_rx_rst) |-> !drp_di[CFG_BIT]) else $error("bit not cleared"); // R2
            AST_RESTORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
                (drp_en && drp_we && !gt_rx_rst) |-> (drp_di == seq_q.word)) else $error("restore data"); // R5
            AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                (busy && !gt_rx_rst) |=> !gt_rx_rst) else $error("reset while busy"); // R9
        end
    endgenerate
endmodule

// File: tb/test_rx_full_reset_seq.sv
module test_rx_full_reset_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_req = 1'b0;
    logic        pma_done = 1'b1;
    logic        drp_rdy = 1'b0;
    logic [15:0] drp_do = '0;
    logic        gt_rx_rst, drp_en, drp_we, busy;
    logic [8:0]  drp_addr;
    logic [15:0] drp_di;

    logic        req_f = 1'b0;
    logic        rst_f, en_f, we_f, busy_f;
    logic [8:0]  addr_f;
    logic [15:0] di_f;

    int          n_chk = 0;
    int          n_fail = 0;
    int          txn = 0;
    int          lat_cfg = 1;
    int          cnt = 0;
    logic        op_we = 1'b0;
    logic [15:0] op_di = '0;
    logic [15:0] mem = '0;
    logic        clr_written = 1'b0;
    logic        done_flag = 1'b0;

    always #2 clk = ~clk;

    rx_full_reset_seq i_rx_full_reset_seq (
        .clk(clk), .rst_n(rst_n), .user_req(user_req), .pma_done(pma_done),
        .drp_rdy(drp_rdy), .drp_do(drp_do), .gt_rx_rst(gt_rx_rst), .drp_en(drp_en),
        .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di), .busy(busy)
    );

    rx_full_reset_seq #(.SIM_SPEEDUP(1'b1)) i_rx_full_reset_seq_fast (
        .clk(clk), .rst_n(rst_n), .user_req(req_f), .pma_done(1'b1),
        .drp_rdy(1'b0), .drp_do(16'h0000), .gt_rx_rst(rst_f), .drp_en(en_f),
        .drp_we(we_f), .drp_addr(addr_f), .drp_di(di_f), .busy(busy_f)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // DRP register model, responds lat_cfg cycles after an enable
    initial begin
        forever begin
            @(negedge clk);
            drp_rdy = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    drp_rdy = 1'b1;
                    if (op_we) begin
                        mem = op_di;
                        if (gt_rx_rst && !op_di[11]) clr_written = 1'b1;
                    end else begin
                        drp_do = mem;
                    end
                end
            end
            if (drp_en) begin
                chk(cnt == 0, "R8 enable while outstanding", cnt, 0);
                chk(drp_addr == 9'h011, "R2 address", drp_addr, 9'h011);
                op_we = drp_we;
                op_di = drp_di;
                cnt   = lat_cfg;
                txn++;
            end
        end
    end

    // reset-release monitor, sampled after each rising edge
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (rst_n && prev && !gt_rx_rst) begin
                chk(clr_written && !user_req, "R3 release condition", {clr_written, user_req}, 2'b10);
            end
            prev = gt_rx_rst;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    task automatic run_seq(input logic [15:0] orig, input int lat, input int hold);
        int t0;
        int waited;
        @(negedge clk);
        clr_written = 1'b0;
        mem = orig;
        lat_cfg = lat;
        t0 = txn;
        user_req = 1'b1;
        @(posedge clk); #1;
        chk(gt_rx_rst && busy, "R1 reset and busy on request", {gt_rx_rst, busy}, 2'b11);
        for (int i = 0; i < hold; i++) @(negedge clk);
        if (hold > 2 * lat + 4)
            chk(gt_rx_rst && clr_written, "R3 held while request high", {gt_rx_rst, clr_written}, 2'b11);
        user_req = 1'b0;
        waited = 0;
        while (gt_rx_rst && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        chk(!gt_rx_rst, "R3 reset released", gt_rx_rst, 0);
        chk(mem == (orig & 16'hF7FF), "R2 cleared word", mem, orig & 16'hF7FF);
        chk(txn - t0 == 2, "R2 read then write", txn - t0, 2);
        repeat (3) @(negedge clk);
        user_req = 1'b1;
        @(negedge clk);
        user_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(!gt_rx_rst && busy, "R9 request ignored while busy", {gt_rx_rst, busy}, 2'b01);
        chk(txn - t0 == 2, "R4 no transaction before fall", txn - t0, 2);
        pma_done = 1'b0;
        waited = 0;
        while (busy && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk(!busy, "R6 busy cleared", busy, 0);
        chk(waited <= lat + 3, "R6 restore cycles", waited, lat + 3);
        chk(mem == orig, "R5 restored word", mem, orig);
        chk(txn - t0 == 3, "R5 restore write count", txn - t0, 3);
        repeat (10) @(negedge clk);
        pma_done = 1'b1;
        repeat (3) @(negedge clk);
        chk(!gt_rx_rst && !busy && txn - t0 == 3, "R9 quiet after sequence", txn - t0, 3);
    endtask

    initial begin
        logic [15:0] pats [4];
        int lats [3];
        int holds [2];
        pats[0] = 16'hFFFF; pats[1] = 16'h0800; pats[2] = 16'h1234; pats[3] = 16'hA5F7;
        lats[0] = 1; lats[1] = 2; lats[2] = 4;
        holds[0] = 1; holds[1] = 14;
        repeat (3) @(negedge clk);
        chk(!gt_rx_rst && !busy && !drp_en, "R1 reset state", {gt_rx_rst, busy, drp_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p < 4; p++)
            for (int l = 0; l < 3; l++)
                for (int h = 0; h < 2; h++)
                    run_seq(pats[p], lats[l], holds[h]);
        // bypass instance: request pattern sweep
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            req_f = logic'((k * 37 + k / 3) % 2);
            @(posedge clk); #1;
            chk(rst_f == req_f, "R7 bypass follows request", rst_f, req_f);
            chk(!en_f && !busy_f, "R7 bypass quiet", {en_f, busy_f}, 0);
        end
        done_flag = 1'b1;
        summary();
    end
endmodule